// File: doc/BRIEF.md
# Bus Master Burst Tenure Limiter

This block caps how long a bus initiator may keep bursting once it has won a shared, PCI-style bus. Software programs an 8-bit reload value. Each time the initiator starts a transaction, the block loads that value into a down-counter and asserts `frameStart` with it. The counter then drops by one on every clock for as long as the burst stays active.

When the counter has run out and the arbiter has taken the internal grant away, the block raises `endBurst` for one clock. That pulse tells the initiator to release FRAME# and end its tenure. If the grant is still held after expiry, the initiator keeps the bus and no request is made. A reload value of zero turns expiry off, so an initiator that keeps its grant can hold the bus for as long as it likes. When the burst ends, the counter goes back to idle.

Top module: `burst_tenure_limiter`

## Requirements
- R1: The reload register is 8 bits wide and resets to 00h. A write (`cfgWrEn` high at a clock edge) stores `cfgWrData`, and `cfgRdData` shows the stored value from the next cycle on.
- R2: Number the clock edge that samples `frameStart` high as edge 0. With a nonzero reload value N loaded at that edge and `burstActive` held high, the counter decreases by one per edge and reaches zero after edge N. It then holds at zero and never counts below it.
- R3: Once the counter has expired, a low `grantIn` sampled at an edge makes `endBurst` high after that edge. If the grant is first low at edge g, `endBurst` is high after edge max(N+1, g).
- R4: While `grantIn` stays high, `endBurst` stays low, even after the counter has expired.
- R5: A reload value of 00h means the timer never expires: `endBurst` stays low for the whole burst, whatever `grantIn` does.
- R6: `endBurst` is a one-cycle pulse and is given at most once per tenure.
- R7: A low `burstActive` sampled at an edge without `frameStart` ends the tenure and returns the counter to idle. After that, dropping the grant produces no `endBurst`. A later `frameStart` loads the full reload value again.
- R8: A register write during a tenure does not change the count already running. The new value is used from the next `frameStart` on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the reload register |
| cfgWrData | input | 8 | Reload value to write |
| cfgRdData | output | 8 | Current reload register contents |
| grantIn | input | 1 | Internal bus grant to this initiator |
| frameStart | input | 1 | Initiator begins a cycle (FRAME# asserted) |
| burstActive | input | 1 | Burst still in progress |
| endBurst | output | 1 | One-cycle request to deassert FRAME# |

## Verification
The assertions check these rules on every cycle:
- a pulse never lasts two cycles;
- a pulse only follows a sampled low grant while the counter sat at zero;
- the counter only rises on a load;
- a tenure running with zero reload never produces a pulse;
- register writes read back.

Some behaviour can only be shown by the bench's scenarios. These are the exact edge on which the pulse appears for each pair of reload value and grant-drop time, the absence of any pulse while the grant is held, the return to idle at burst end, and that a write in mid-tenure does not touch the running count.

// File: rtl/blt_pkg.sv
package blt_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COUNT     = 2'd1,
    ST_UNLIMITED = 2'd2,
    ST_DONE      = 2'd3
  } tenureState_t;
endpackage

// File: rtl/blt_datapath.sv
module blt_datapath
  import blt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CNT_W-1:0] cfgWrData,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] reloadValue,
  output logic [CNT_W-1:0] tenureCount,
  output logic             countZero,
  output logic             reloadZero
);
  localparam logic [CNT_W-1:0] ZERO_VAL = '0;
  localparam logic [CNT_W-1:0] ONE_VAL  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] countNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= ZERO_VAL;
    end else if (cfgWrEn) begin
      reloadReg <= cfgWrData;
    end
  end

  always_comb begin
    countNext = countReg;
    if (strobes.load) begin
      countNext = reloadReg;
    end else if (strobes.clear) begin
      countNext = ZERO_VAL;
    end else if (strobes.dec && (countReg != ZERO_VAL)) begin
      countNext = countReg - ONE_VAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= ZERO_VAL;
    end else begin
      countReg <= countNext;
    end
  end

  assign reloadValue = reloadReg;
  assign tenureCount = countReg;
  assign countZero   = (countReg == ZERO_VAL);
  assign reloadZero  = (reloadReg == ZERO_VAL);
endmodule

// File: rtl/blt_control.sv
module blt_control
  import blt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         burstActive,
  input  logic         grantIn,
  input  logic         countZero,
  input  logic         reloadZero,
  output ctrlStrobes_t strobes,
  output logic         unlimited,
  output logic         endBurst
);
  tenureState_t state;
  tenureState_t stateNext;
  logic         fire;
  logic         endReg;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    fire      = 1'b0;
    if (frameStart) begin
      strobes.load = 1'b1;
      stateNext    = reloadZero ? ST_UNLIMITED : ST_COUNT;
    end else if (!burstActive) begin
      strobes.clear = 1'b1;
      stateNext     = ST_IDLE;
    end else begin
      unique case (state)
        ST_COUNT: begin
          if (!countZero) begin
            strobes.dec = 1'b1;
          end else if (!grantIn) begin
            fire      = 1'b1;
            stateNext = ST_DONE;
          end
        end
        ST_UNLIMITED: stateNext = ST_UNLIMITED;
        ST_DONE:      stateNext = ST_DONE;
        default:      stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      endReg <= 1'b0;
    end else begin
      state  <= stateNext;
      endReg <= fire;
    end
  end

  assign unlimited = (state == ST_UNLIMITED);
  assign endBurst  = endReg;
endmodule

// File: rtl/burst_tenure_limiter.sv
module burst_tenure_limiter
  import blt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CNT_W-1:0] cfgWrData,
  output logic [CNT_W-1:0] cfgRdData,
  input  logic             grantIn,
  input  logic             frameStart,
  input  logic             burstActive,
  output logic             endBurst
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] tenureCount;
  logic             countZero;
  logic             reloadZero;
  logic             unlimited;

  blt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .strobes    (strobes),
    .reloadValue(cfgRdData),
    .tenureCount(tenureCount),
    .countZero  (countZero),
    .reloadZero (reloadZero)
  );

  blt_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .burstActive(burstActive),
    .grantIn    (grantIn),
    .countZero  (countZero),
    .reloadZero (reloadZero),
    .strobes    (strobes),
    .unlimited  (unlimited),
    .endBurst   (endBurst)
  );
endmodule

// File: rtl/blt_checker.sv
module blt_checker
  import blt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [CNT_W-1:0] cfgWrData,
  input logic [CNT_W-1:0] cfgRdData,
  input logic             grantIn,
  input logic             endBurst,
  input ctrlStrobes_t     strobes,
  input logic [CNT_W-1:0] tenureCount,
  input logic             unlimited
);
  assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData == $past(cfgWrData)));

  assert_count_never_rises_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> (tenureCount <= $past(tenureCount)));

  assert_end_needs_grant_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endBurst) |-> !$past(grantIn));

  assert_end_after_expiry_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endBurst) |-> ($past(tenureCount) == '0));

  assert_unlimited_no_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    unlimited |=> !endBurst);

  assert_end_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    endBurst |=> !endBurst);
endmodule

bind burst_tenure_limiter blt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .cfgRdData  (cfgRdData),
  .grantIn    (grantIn),
  .endBurst   (endBurst),
  .strobes    (strobes),
  .tenureCount(tenureCount),
  .unlimited  (unlimited)
);

// File: tb/tb_burst_tenure_limiter.sv
`timescale 1ns/1ps
module tb_burst_tenure_limiter;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn;
  logic [7:0] cfgWrData;
  logic [7:0] cfgRdData;
  logic       grantIn;
  logic       frameStart;
  logic       burstActive;
  logic       endBurst;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_tenure_limiter dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .grantIn(grantIn), .frameStart(frameStart),
    .burstActive(burstActive), .endBurst(endBurst)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R7", endBurst, 0);
    end
  endtask

  // One tenure: frameStart sampled at edge 0, grant low from edge g onward.
  task automatic runTenure(input int n, input int g, input int window);
    int expEdge;
    string tag;
    expEdge = (n == 0) ? -1 : ((n + 1 > g) ? n + 1 : g);
    @(negedge clk);
    frameStart = 1'b1; burstActive = 1'b1; grantIn = (g > 0);
    for (int t = 0; t <= window; t++) begin
      @(negedge clk);
      if (n == 0) tag = "R5";
      else if (expEdge >= 0 && t == expEdge) tag = "R3";
      else if (expEdge >= 0 && t > expEdge) tag = "R6";
      else tag = (t > n) ? "R4" : "R2";
      check(tag, endBurst, (t == expEdge) ? 1 : 0);
      frameStart = 1'b0;
      grantIn = (t + 1 < g);
    end
    burstActive = 1'b0; grantIn = 1'b1;
    @(negedge clk);
    check("R7", endBurst, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0;
    grantIn = 1'b1; frameStart = 1'b0; burstActive = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", cfgRdData, 0);
    check("R1", endBurst, 0);

    // R1: full sweep of register values
    for (int v = 0; v < 256; v++) begin
      writeReg(v[7:0]);
      check("R1", cfgRdData, v);
    end

    // R2 R3 R4 R5 R6: sweep reload value and grant-drop edge
    for (int n = 0; n <= 12; n++) begin
      writeReg(n[7:0]);
      for (int g = 1; g <= n + 4; g++) runTenure(n, g, 30);
      runTenure(n, 99, 30);
    end

    // R7: burst ends before expiry, later grant drop yields nothing
    writeReg(8'd3);
    @(negedge clk);
    frameStart = 1'b1; burstActive = 1'b1; grantIn = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    @(negedge clk);
    burstActive = 1'b0;
    @(negedge clk);
    grantIn = 1'b0;
    idleCycles(10);
    grantIn = 1'b1;
    // R7: fresh tenure reloads the full count
    runTenure(3, 1, 12);

    // R8: write during a tenure does not change the running count
    writeReg(8'd5);
    @(negedge clk);
    frameStart = 1'b1; burstActive = 1'b1; grantIn = 1'b0;
    for (int t = 0; t <= 12; t++) begin
      @(negedge clk);
      check("R8", endBurst, (t == 6) ? 1 : 0);
      frameStart = 1'b0;
      cfgWrEn = (t == 0); cfgWrData = 8'd1;
    end
    cfgWrEn = 1'b0;
    burstActive = 1'b0; grantIn = 1'b1;
    @(negedge clk);
    check("R8", cfgRdData, 1);
    runTenure(1, 1, 8);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule